// File: doc/BRIEF.md
# Tagged Transmit FIFO Write Port for a Serial Flash Controller

This block is the register-side front end of a serial flash controller's data path. Software pushes 32-bit words through one of four write addresses. The address chosen decides how many bytes of that word, from one to four, are later shifted onto the serial lines. Each FIFO entry stores that byte count next to its data, so a transfer shorter than a word needs no separate length setting. A downstream byte shifter takes bytes over a valid/ready handshake, starting from the least significant lane. The shifter returns one received byte for every byte sent, and marks the last byte of each entry.

Received bytes are packed back into words. The bytes of a short entry end up in the upper lanes, and the lower lanes read as zero. Software pops those words from a receive data address. Two programmable marks produce level flags. The transmit side reports when occupancy is below its mark. The receive side reports when occupancy has reached its mark.

Software must let the transmit FIFO drain before it changes write size. A write of a different size while entries are still pending is rejected and flagged.

A two-state sequencer moves bytes to the shifter. In `SER_IDLE` it waits, and it takes the transition to `SER_SHIFT` when the FIFO holds an entry. In `SER_SHIFT` it presents the byte lanes of the head entry in turn. It takes the transition back to `SER_IDLE` when the shifter accepts the entry's last byte, and the entry is popped at that moment.

Top module: `qspi_txw_port`

## Requirements
- R1: A write to 0x1C queues a 4-byte entry, 0x80 a 1-byte entry, 0x84 a 2-byte entry and 0x88 a 3-byte entry. The bytes of an entry go to the shifter starting from bits 7:0 and moving up, and `sh_tx_last` is high only with the final byte of the entry.
- R2: After reset the transmit FIFO is empty and not full, `tx_below_mark` is high, the receive FIFO is empty, and 0x28 and 0x2C read back 1 and RX_MARK_RST.
- R3: `tx_full` rises once TX_DEPTH entries are pending. A transmit write made while the FIFO is full is dropped, and `evt_tx_overflow` pulses for the one cycle after it.
- R4: A transmit write whose size differs from the size of the pending entries, made while the transmit FIFO is not empty, is dropped and pulses `evt_wr_size_err` for one cycle. A write of the same size is accepted. Once the FIFO is empty, a write of any size is accepted.
- R5: `tx_below_mark` is high exactly when transmit occupancy is less than the transmit mark. Software writes the mark through 0x28, using its low bits.
- R6: While `sh_tx_valid` is high and `sh_tx_ready` is low, `sh_tx_valid`, `sh_tx_byte` and `sh_tx_last` hold their values.
- R7: Received bytes up to and including one marked `sh_rx_last` form one word. For N such bytes, the first byte lands in lane 4-N and the following bytes in the lanes above it, while the lanes below read zero. A read at 0x20 returns the oldest such word on `reg_rdata` in the cycle after the read.
- R8: A read at 0x20 while the receive FIFO is empty returns zero and pulses `evt_rx_underflow` for one cycle.
- R9: `rx_at_mark` is high exactly when receive occupancy is at or above the receive mark. Software writes the mark through 0x2C.
- R10: An entry counts as pending until the shifter accepts its last byte. `tx_empty` rises only after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| tx_empty | output | 1 | No transmit entry pending |
| tx_full | output | 1 | Transmit FIFO holds TX_DEPTH entries |
| tx_below_mark | output | 1 | Transmit occupancy below the transmit mark |
| rx_not_empty | output | 1 | Receive FIFO holds at least one word |
| rx_at_mark | output | 1 | Receive occupancy at or above the receive mark |
| evt_wr_size_err | output | 1 | One-cycle pulse: mismatched-size write rejected |
| evt_tx_overflow | output | 1 | One-cycle pulse: write to a full FIFO dropped |
| evt_rx_underflow | output | 1 | One-cycle pulse: read of an empty receive FIFO |
| sh_tx_valid | output | 1 | Byte offered to the shifter |
| sh_tx_ready | input | 1 | Shifter accepts the offered byte |
| sh_tx_byte | output | 8 | Byte to shift |
| sh_tx_last | output | 1 | Offered byte is the last one of its entry |
| sh_rx_valid | input | 1 | Received byte strobe |
| sh_rx_byte | input | 8 | Received byte |
| sh_rx_last | input | 1 | Received byte closes a word |

## Verification
The bench builds the block with TX_DEPTH of 5, RX_DEPTH of 4 and RX_MARK_RST of 2. With these values, the full flag, a dropped overflow write and a receive mark crossing all occur within a handful of writes, instead of after sixty-odd. Holding the shifter's ready low parks an entry in `SER_SHIFT`. This shows that a pending entry blocks a size change, and that the offered byte stays put while the shifter stalls. The receive FIFO is smaller than the transmit FIFO in this build. Draining five entries therefore fills the receive FIFO, and the mark flag can be watched as words are popped one at a time.

// File: rtl/qspi_txw_pkg.sv
package qspi_txw_pkg;

    localparam int WORD_W = 32;

    // Register addresses (byte offsets)
    localparam logic [7:0] A_TX_4B   = 8'h1C;
    localparam logic [7:0] A_RX_DATA = 8'h20;
    localparam logic [7:0] A_TX_MARK = 8'h28;
    localparam logic [7:0] A_RX_MARK = 8'h2C;
    localparam logic [7:0] A_TX_1B   = 8'h80;
    localparam logic [7:0] A_TX_2B   = 8'h84;
    localparam logic [7:0] A_TX_3B   = 8'h88;

    // Byte count tag holds (valid bytes - 1)
    typedef logic [1:0] szcode_t;

    typedef struct packed {
        szcode_t             sz;
        logic [WORD_W-1:0]   data;
    } tx_entry_t;

    localparam int ENTRY_W = $bits(tx_entry_t);

    typedef enum logic {
        SER_IDLE,
        SER_SHIFT
    } ser_state_e;

endpackage

// File: rtl/qspi_txw_fifo.sv
module qspi_txw_fifo #(
    parameter int WIDTH = 34,
    parameter int DEPTH = 63,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);

    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0] count_q;
    logic             do_push, do_pop;

    assign full    = (count_q == CNT_W'(DEPTH));
    assign empty   = (count_q == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem_q[rd_ptr_q];
    assign count   = count_q;

    always_ff @(posedge clk) begin
        if (do_push) mem_q[wr_ptr_q] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (do_push) wr_ptr_q <= (wr_ptr_q == LAST_SLOT) ? '0 : wr_ptr_q + 1'b1;
            if (do_pop)  rd_ptr_q <= (rd_ptr_q == LAST_SLOT) ? '0 : rd_ptr_q + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_W'(DEPTH)); // R3
    AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty); // R10

endmodule

// File: rtl/qspi_txw_serializer.sv
module qspi_txw_serializer
    import qspi_txw_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  tx_entry_t head,
    input  logic      fifo_empty,
    input  logic      sh_tx_ready,
    output logic      sh_tx_valid,
    output logic [7:0] sh_tx_byte,
    output logic      sh_tx_last,
    output logic      pop
);
    ser_state_e state_q, state_d;
    szcode_t    idx_q, idx_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SER_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            SER_IDLE: begin
                idx_d = '0;
                if (!fifo_empty) state_d = SER_SHIFT;
            end
            SER_SHIFT: begin
                if (sh_tx_ready) begin
                    if (idx_q == head.sz) begin
                        idx_d   = '0;
                        state_d = SER_IDLE;
                    end else begin
                        idx_d = idx_q + 1'b1;
                    end
                end
            end
            default: state_d = SER_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        sh_tx_valid = 1'b0;
        sh_tx_last  = 1'b0;
        sh_tx_byte  = head.data[{idx_q, 3'b000} +: 8];
        pop         = 1'b0;
        unique case (state_q)
            SER_IDLE: ;
            SER_SHIFT: begin
                sh_tx_valid = 1'b1;
                sh_tx_last  = (idx_q == head.sz);
                pop         = sh_tx_ready && (idx_q == head.sz);
            end
            default: ;
        endcase
    end

    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_tx_valid && !sh_tx_ready) |=>
            (sh_tx_valid && $stable(sh_tx_byte) && $stable(sh_tx_last))); // R6
    AST_ENTRY_CONTINUES: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_tx_valid && sh_tx_ready && !sh_tx_last) |=> sh_tx_valid); // R1

endmodule

// File: rtl/qspi_txw_rx_pack.sv
module qspi_txw_rx_pack
    import qspi_txw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic              rx_last,
    output logic              word_valid,
    output logic [WORD_W-1:0] word
);
    logic [WORD_W-1:0] acc_q;
    logic [WORD_W-1:0] shifted;

    // Each byte enters at the top lane; earlier bytes move down one lane.
    assign shifted    = {rx_byte, acc_q[WORD_W-1:8]};
    assign word_valid = rx_valid && rx_last;
    assign word       = shifted;

    always_ff @(posedge clk) begin
        if (!rst_n)                acc_q <= '0;
        else if (rx_valid) begin
            if (rx_last)           acc_q <= '0;
            else                   acc_q <= shifted;
        end
    end

    AST_PACK_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_last) |=> (acc_q == '0)); // R7

endmodule

// File: rtl/qspi_txw_port.sv
module qspi_txw_port
    import qspi_txw_pkg::*;
#(
    parameter int TX_DEPTH    = 63,
    parameter int RX_DEPTH    = 63,
    parameter int TX_MARK_RST = 1,
    parameter int RX_MARK_RST = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr_en,
    input  logic        reg_rd_en,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        tx_empty,
    output logic        tx_full,
    output logic        tx_below_mark,
    output logic        rx_not_empty,
    output logic        rx_at_mark,
    output logic        evt_wr_size_err,
    output logic        evt_tx_overflow,
    output logic        evt_rx_underflow,
    output logic        sh_tx_valid,
    input  logic        sh_tx_ready,
    output logic [7:0]  sh_tx_byte,
    output logic        sh_tx_last,
    input  logic        sh_rx_valid,
    input  logic [7:0]  sh_rx_byte,
    input  logic        sh_rx_last
);
    localparam int TX_CNT_W = $clog2(TX_DEPTH + 1);
    localparam int RX_CNT_W = $clog2(RX_DEPTH + 1);

    // Address decode
    logic    is_tx_wr;
    szcode_t wr_sz;
    always_comb begin
        is_tx_wr = 1'b0;
        wr_sz    = 2'd3;
        if (reg_wr_en) begin
            unique case (reg_addr)
                A_TX_4B: begin is_tx_wr = 1'b1; wr_sz = 2'd3; end
                A_TX_1B: begin is_tx_wr = 1'b1; wr_sz = 2'd0; end
                A_TX_2B: begin is_tx_wr = 1'b1; wr_sz = 2'd1; end
                A_TX_3B: begin is_tx_wr = 1'b1; wr_sz = 2'd2; end
                default: ;
            endcase
        end
    end

    // Transmit FIFO
    tx_entry_t           tx_wentry, tx_head;
    logic [TX_CNT_W-1:0] tx_count;
    logic                tx_push, tx_pop, size_err, ovf;
    szcode_t             last_sz_q;

    assign size_err  = is_tx_wr && !tx_empty && (wr_sz != last_sz_q);
    assign ovf       = is_tx_wr && !size_err && tx_full;
    assign tx_push   = is_tx_wr && !size_err && !tx_full;
    assign tx_wentry = '{sz: wr_sz, data: reg_wdata};

    qspi_txw_fifo #(.WIDTH(ENTRY_W), .DEPTH(TX_DEPTH)) u_tx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (tx_push),
        .wdata (tx_wentry),
        .pop   (tx_pop),
        .head  (tx_head),
        .count (tx_count),
        .full  (tx_full),
        .empty (tx_empty)
    );

    qspi_txw_serializer u_ser (
        .clk         (clk),
        .rst_n       (rst_n),
        .head        (tx_head),
        .fifo_empty  (tx_empty),
        .sh_tx_ready (sh_tx_ready),
        .sh_tx_valid (sh_tx_valid),
        .sh_tx_byte  (sh_tx_byte),
        .sh_tx_last  (sh_tx_last),
        .pop         (tx_pop)
    );

    // Receive path
    logic                rx_word_valid, rx_push, rx_pop, rx_full, rx_empty, rd_rx;
    logic [WORD_W-1:0]   rx_word, rx_head;
    logic [RX_CNT_W-1:0] rx_count;

    qspi_txw_rx_pack u_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_valid   (sh_rx_valid),
        .rx_byte    (sh_rx_byte),
        .rx_last    (sh_rx_last),
        .word_valid (rx_word_valid),
        .word       (rx_word)
    );

    assign rx_push = rx_word_valid && !rx_full;
    assign rd_rx   = reg_rd_en && (reg_addr == A_RX_DATA);
    assign rx_pop  = rd_rx && !rx_empty;

    qspi_txw_fifo #(.WIDTH(WORD_W), .DEPTH(RX_DEPTH)) u_rx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (rx_push),
        .wdata (rx_word),
        .pop   (rx_pop),
        .head  (rx_head),
        .count (rx_count),
        .full  (rx_full),
        .empty (rx_empty)
    );

    // Marks, events, read data
    logic [TX_CNT_W-1:0] tx_mark_q;
    logic [RX_CNT_W-1:0] rx_mark_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_mark_q        <= TX_CNT_W'(TX_MARK_RST);
            rx_mark_q        <= RX_CNT_W'(RX_MARK_RST);
            last_sz_q        <= 2'd3;
            evt_wr_size_err  <= 1'b0;
            evt_tx_overflow  <= 1'b0;
            evt_rx_underflow <= 1'b0;
            reg_rdata        <= '0;
        end else begin
            if (reg_wr_en && reg_addr == A_TX_MARK) tx_mark_q <= reg_wdata[TX_CNT_W-1:0];
            if (reg_wr_en && reg_addr == A_RX_MARK) rx_mark_q <= reg_wdata[RX_CNT_W-1:0];
            if (tx_push) last_sz_q <= wr_sz;
            evt_wr_size_err  <= size_err;
            evt_tx_overflow  <= ovf;
            evt_rx_underflow <= rd_rx && rx_empty;
            if (reg_rd_en) begin
                unique case (reg_addr)
                    A_RX_DATA: reg_rdata <= rx_empty ? '0 : rx_head;
                    A_TX_MARK: reg_rdata <= 32'(tx_mark_q);
                    A_RX_MARK: reg_rdata <= 32'(rx_mark_q);
                    default:   reg_rdata <= '0;
                endcase
            end
        end
    end

    assign tx_below_mark = (tx_count < tx_mark_q);
    assign rx_not_empty  = !rx_empty;
    assign rx_at_mark    = (rx_count >= rx_mark_q);

    AST_OVF_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        evt_tx_overflow |-> $past(tx_full)); // R3
    AST_SIZE_ERR_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        evt_wr_size_err |-> $past(!tx_empty)); // R4
    AST_UNDERFLOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        evt_rx_underflow |-> (reg_rdata == '0)); // R8
    AST_EVT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(evt_wr_size_err && evt_tx_overflow)); // R4

endmodule

// File: tb/qspi_txw_port_tb_top.sv
module qspi_txw_port_tb_top;
    localparam int TXD = 5;
    localparam int RXD = 4;
    localparam int RXM = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr_en = 1'b0, reg_rd_en = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic tx_empty, tx_full, tx_below_mark, rx_not_empty, rx_at_mark;
    logic evt_wr_size_err, evt_tx_overflow, evt_rx_underflow;
    logic sh_tx_valid, sh_tx_last;
    logic [7:0] sh_tx_byte;
    logic sh_tx_ready = 1'b0;
    logic sh_rx_valid = 1'b0, sh_rx_last = 1'b0;
    logic [7:0] sh_rx_byte = '0;

    int checks = 0;
    int errors = 0;
    logic rdy_on = 1'b0;
    logic [8:0]  exp_tx_q[$];
    logic [31:0] exp_rx_q[$];

    always #4 clk = ~clk;

    qspi_txw_port #(.TX_DEPTH(TXD), .RX_DEPTH(RXD), .RX_MARK_RST(RXM)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_empty(tx_empty), .tx_full(tx_full), .tx_below_mark(tx_below_mark),
        .rx_not_empty(rx_not_empty), .rx_at_mark(rx_at_mark),
        .evt_wr_size_err(evt_wr_size_err), .evt_tx_overflow(evt_tx_overflow),
        .evt_rx_underflow(evt_rx_underflow), .sh_tx_valid(sh_tx_valid),
        .sh_tx_ready(sh_tx_ready), .sh_tx_byte(sh_tx_byte), .sh_tx_last(sh_tx_last),
        .sh_rx_valid(sh_rx_valid), .sh_rx_byte(sh_rx_byte), .sh_rx_last(sh_rx_last)
    );

    task automatic check(input logic ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd_en = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd_en = 1'b0;
        d = reg_rdata;
    endtask

    function automatic logic [7:0] addr_for(input int nb);
        case (nb)
            1: return 8'h80;
            2: return 8'h84;
            3: return 8'h88;
            default: return 8'h1C;
        endcase
    endfunction

    // Driver: record expected shifter bytes (and packed receive word), then write.
    task automatic tx_send(input int nb, input logic [31:0] d, input logic want_rx);
        logic [31:0] w = '0;
        for (int k = 0; k < nb; k++) begin
            exp_tx_q.push_back({(k == nb - 1), d[k*8 +: 8]});
            w[(4 - nb + k)*8 +: 8] = d[k*8 +: 8];
        end
        if (want_rx) exp_rx_q.push_back(w);
        bus_wr(addr_for(nb), d);
    endtask

    task automatic wait_drain();
        while (exp_tx_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic rx_pop_check(input string req);
        logic [31:0] got;
        logic [31:0] exp;
        bus_rd(8'h20, got);
        exp = (exp_rx_q.size() != 0) ? exp_rx_q.pop_front() : 32'hDEAD_DEAD;
        check(got == exp, req, got, exp);
    endtask

    // Monitor: drives ready, checks each accepted byte, echoes it as received data.
    initial begin
        forever begin
            @(negedge clk);
            sh_rx_valid = 1'b0;
            sh_tx_ready = rdy_on;
            if (sh_tx_valid && sh_tx_ready) begin
                logic [8:0] e;
                e = (exp_tx_q.size() != 0) ? exp_tx_q.pop_front() : 9'h1FF;
                check({sh_tx_last, sh_tx_byte} == e, "R1 shifter byte/last",
                      {23'd0, sh_tx_last, sh_tx_byte}, {23'd0, e});
                sh_rx_valid = 1'b1;
                sh_rx_byte  = sh_tx_byte;
                sh_rx_last  = sh_tx_last;
            end
        end
    end

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 reset state
        check(tx_empty && !tx_full && tx_below_mark, "R2 tx flags",
              {29'd0, tx_empty, tx_full, tx_below_mark}, 32'h5);
        check(!rx_not_empty && !rx_at_mark, "R2 rx flags",
              {30'd0, rx_not_empty, rx_at_mark}, 32'h0);
        bus_rd(8'h28, rd); check(rd == 32'd1, "R2 tx mark default", rd, 32'd1);
        bus_rd(8'h2C, rd); check(rd == RXM, "R2 rx mark default", rd, RXM);

        // R1 all four sizes, drained one at a time
        rdy_on = 1'b1;
        tx_send(4, 32'h4433_2211, 1'b1); wait_drain();
        tx_send(1, 32'hAABB_CCDD, 1'b1); wait_drain();
        tx_send(2, 32'h1234_5678, 1'b1); wait_drain();
        tx_send(3, 32'h9ABC_DEF0, 1'b1); wait_drain();
        check(exp_tx_q.size() == 0, "R1 all bytes seen", exp_tx_q.size(), 0);
        check(tx_empty, "R10 empty after drain", tx_empty, 1);

        // R9 rx mark reached with four words, R7 packing order
        check(rx_at_mark && rx_not_empty, "R9 rx at mark", rx_at_mark, 1);
        rx_pop_check("R7 word 4B");
        rx_pop_check("R7 word 1B");
        rx_pop_check("R7 word 2B");
        rx_pop_check("R7 word 3B");
        check(!rx_not_empty, "R7 rx drained", rx_not_empty, 0);

        // R8 underflow
        bus_rd(8'h20, rd);
        check(rd == 32'd0, "R8 empty read data", rd, 0);
        check(evt_rx_underflow, "R8 underflow event", evt_rx_underflow, 1);

        // R4/R10/R6 size switch blocked while pending
        rdy_on = 1'b0;
        repeat (3) @(negedge clk);
        tx_send(2, 32'h0000_BEEF, 1'b1);
        check(!evt_wr_size_err, "R4 first write ok", evt_wr_size_err, 0);
        repeat (3) @(negedge clk);
        check(!tx_empty, "R10 pending while shifting", tx_empty, 0);
        check(sh_tx_valid && sh_tx_byte == 8'hEF, "R6 held byte", sh_tx_byte, 8'hEF);
        @(negedge clk);
        check(sh_tx_valid && sh_tx_byte == 8'hEF && !sh_tx_last, "R6 still held",
              {23'd0, sh_tx_last, sh_tx_byte}, 32'hEF);
        bus_wr(8'h88, 32'h0077_6655);
        check(evt_wr_size_err, "R4 mismatch flagged", evt_wr_size_err, 1);
        tx_send(2, 32'h0000_CAFE, 1'b1);
        check(!evt_wr_size_err, "R4 same size accepted", evt_wr_size_err, 0);
        rdy_on = 1'b1;
        wait_drain();
        check(tx_empty, "R10 empty after bytes", tx_empty, 1);
        tx_send(3, 32'h0033_2211, 1'b1);
        check(!evt_wr_size_err, "R4 new size after drain", evt_wr_size_err, 0);
        wait_drain();
        rx_pop_check("R7 word BEEF");
        rx_pop_check("R7 word CAFE");
        rx_pop_check("R7 word 3B after drain");

        // R5 mark, R3 full and overflow
        bus_wr(8'h28, 32'd3);
        bus_rd(8'h28, rd); check(rd == 32'd3, "R5 mark readback", rd, 3);
        rdy_on = 1'b0;
        repeat (3) @(negedge clk);
        tx_send(4, 32'h0403_0201, 1'b1);
        check(tx_below_mark, "R5 count1 below", tx_below_mark, 1);
        tx_send(4, 32'h0807_0605, 1'b1);
        check(tx_below_mark, "R5 count2 below", tx_below_mark, 1);
        tx_send(4, 32'h0C0B_0A09, 1'b1);
        check(!tx_below_mark, "R5 count3 not below", tx_below_mark, 0);
        tx_send(4, 32'h100F_0E0D, 1'b1);
        check(!tx_full, "R3 not yet full", tx_full, 0);
        tx_send(4, 32'h1413_1211, 1'b0);
        check(tx_full, "R3 full at depth", tx_full, 1);
        bus_wr(8'h1C, 32'hFFFF_FFFF);
        check(evt_tx_overflow && tx_full, "R3 overflow event",
              {30'd0, evt_tx_overflow, tx_full}, 32'h3);
        @(negedge clk);
        check(!evt_tx_overflow, "R3 overflow one cycle", evt_tx_overflow, 0);
        rdy_on = 1'b1;
        wait_drain();
        check(exp_tx_q.size() == 0 && tx_empty, "R3 dropped word not sent", tx_empty, 1);

        // R9 mark crossing while popping
        check(rx_at_mark, "R9 rx full at mark", rx_at_mark, 1);
        rx_pop_check("R7 burst word 1");
        rx_pop_check("R7 burst word 2");
        check(rx_at_mark, "R9 two words at mark", rx_at_mark, 1);
        rx_pop_check("R7 burst word 3");
        check(!rx_at_mark && rx_not_empty, "R9 one word below mark",
              {30'd0, rx_at_mark, rx_not_empty}, 32'h1);
        rx_pop_check("R7 burst word 4");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule